// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the 32-bit memory address for a load or store operand on a 32-bit CPU. It offers four addressing modes. Two add a displacement to a base register. The other two add the R0 index register to a base. The base is either the general register Rn or the global base register. A displacement is always zero-extended. It is then scaled to the operand size, so one displacement step moves by one byte, one word or one longword.

Each request is a one-cycle strobe that carries the mode, the operand size, the three register values and the raw displacement field. One clock later the block presents the address with a one-cycle valid pulse. It also flags whether the address breaks the natural alignment of the operand size and reports which base register it used. An illegal size code gives a one-cycle error pulse in place of a result.

Top module: `ldst_ea_gen`

## Requirements
- R1: Mode 00 (short base displacement): the address is Rn + zext(disp[3:0]) scaled by size. Bits 7:4 of the displacement input have no effect.
- R2: Mode 10 (global base displacement): the address is GBR + zext(disp[7:0]) scaled by size.
- R3: Size 00 (byte) scales the displacement by 1, size 01 (word) by 2, and size 10 (longword) by 4. The furthest reach is therefore 60 bytes in mode 00 and 1020 bytes in mode 10.
- R4: Mode 01 (register index): the address is Rn + R0 with no scaling, and the displacement input has no effect.
- R5: Mode 11 (global base index): the address is GBR + R0 with no scaling, and the displacement input has no effect.
- R6: Every addition is modulo 2^32, and any carry out of bit 31 is dropped.
- R7: A request with size 11 pulses ea_size_err for one cycle with ea_valid low. ea_addr, ea_misalign and ea_base_gbr then keep their previous values.
- R8: ea_misalign is 1 for a word address with bit 0 set. It is also 1 for a longword address with bit 1 or bit 0 set. It is never 1 for a byte access.
- R9: A legal request gives ea_valid high for exactly the next cycle, together with its address and flags. In a cycle after no request, ea_valid and ea_size_err are low and ea_addr holds its value.
- R10: ea_base_gbr is 1 when the result used GBR as its base (modes 10 and 11) and 0 when it used Rn (modes 00 and 01).
- R11: A synchronous reset clears all outputs to 0 and takes priority over a request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, one cycle per address |
| req_mode | input | 2 | Addressing mode: 00 Rn+disp, 01 Rn+R0, 10 GBR+disp, 11 GBR+R0 |
| req_size | input | 2 | Operand size: 00 byte, 01 word, 10 longword, 11 illegal |
| rn_val | input | 32 | Base register Rn value |
| r0_val | input | 32 | Index register R0 value |
| gbr_val | input | 32 | Global base register value |
| disp_raw | input | 8 | Raw displacement field |
| ea_valid | output | 1 | Result valid pulse |
| ea_addr | output | 32 | Effective address |
| ea_misalign | output | 1 | Address is not aligned to the operand size |
| ea_size_err | output | 1 | Illegal size pulse |
| ea_base_gbr | output | 1 | Base used: 1 GBR, 0 Rn |

## Verification
The hardest cases to reach are carries that wrap past 0xFFFFFFFF while the displacement is at its scaled maximum. A second hard case is the upper displacement bits that mode 00 must ignore, which stay invisible unless the other modes are driven with the same field. The stimulus sweeps every displacement value from 0 to 255 against every mode and every size, including the illegal one. It uses base values just below the top of the address space and R0 values with high bits set. In every mode the upper nibble is driven, so any leak into mode 00 or into the index modes changes the address. An idle cycle follows each request to show that the result holds and that no stray pulse appears.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [1:0] {
    EA_RN_DISP  = 2'b00,
    EA_RN_IDX   = 2'b01,
    EA_GBR_DISP = 2'b10,
    EA_GBR_IDX  = 2'b11
  } ea_mode_e;

  typedef enum logic [1:0] {
    EA_SZ_BYTE = 2'b00,
    EA_SZ_WORD = 2'b01,
    EA_SZ_LONG = 2'b10,
    EA_SZ_BAD  = 2'b11
  } ea_size_e;

  // alignment test on the two low address bits
  function automatic logic ea_is_misaligned(input logic [1:0] lo, input ea_size_e sz);
    case (sz)
      EA_SZ_WORD: ea_is_misaligned = lo[0];
      EA_SZ_LONG: ea_is_misaligned = |lo;
      default:    ea_is_misaligned = 1'b0;
    endcase
  endfunction

  function automatic logic ea_uses_gbr(input ea_mode_e m);
    ea_uses_gbr = (m == EA_GBR_DISP) || (m == EA_GBR_IDX);
  endfunction

endpackage

// File: rtl/ea_base_sel.sv
module ea_base_sel
  import ea_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] rn,
  input  logic [ADDR_W-1:0] gbr,
  output logic [ADDR_W-1:0] base,
  output logic              base_is_gbr
);

  ea_mode_e mode_e;

  always_comb begin
    mode_e      = ea_mode_e'(mode);
    base_is_gbr = ea_uses_gbr(mode_e);
    base        = base_is_gbr ? gbr : rn;
  end

endmodule

// File: rtl/ea_offset_sel.sv
module ea_offset_sel
  import ea_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DISP_W  = 8,
  parameter int SHORT_W = 4
) (
  input  logic [1:0]        mode,
  input  logic [1:0]        size,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] r0,
  output logic [ADDR_W-1:0] offset
);

  localparam int PAD_W   = ADDR_W - DISP_W;
  localparam int SHPAD_W = DISP_W - SHORT_W;

  // zero-extend, then shift left by log2 of the operand byte count
  function automatic logic [ADDR_W-1:0] scale_disp(input logic [DISP_W-1:0] d,
                                                  input ea_size_e sz);
    logic [ADDR_W-1:0] z;
    z = {{PAD_W{1'b0}}, d};
    case (sz)
      EA_SZ_BYTE: scale_disp = z;
      EA_SZ_WORD: scale_disp = z << 1;
      EA_SZ_LONG: scale_disp = z << 2;
      default:    scale_disp = '0;
    endcase
  endfunction

  logic [DISP_W-1:0] short_disp;
  ea_mode_e          mode_e;
  ea_size_e          size_e;

  always_comb begin
    mode_e     = ea_mode_e'(mode);
    size_e     = ea_size_e'(size);
    short_disp = {{SHPAD_W{1'b0}}, disp[SHORT_W-1:0]};
    case (mode_e)
      EA_RN_DISP:  offset = scale_disp(short_disp, size_e);
      EA_GBR_DISP: offset = scale_disp(disp, size_e);
      default:     offset = r0;
    endcase
  end

endmodule

// File: rtl/ea_align_chk.sv
module ea_align_chk
  import ea_pkg::*;
(
  input  logic [1:0] addr_lo,
  input  logic [1:0] size,
  output logic       misaligned,
  output logic       size_bad
);

  ea_size_e size_e;

  always_comb begin
    size_e     = ea_size_e'(size);
    size_bad   = (size_e == EA_SZ_BAD);
    misaligned = ea_is_misaligned(addr_lo, size_e);
  end

endmodule

// File: rtl/ldst_ea_gen.sv
module ldst_ea_gen
  import ea_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DISP_W  = 8,
  parameter int SHORT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] rn_val,
  input  logic [ADDR_W-1:0] r0_val,
  input  logic [ADDR_W-1:0] gbr_val,
  input  logic [DISP_W-1:0] disp_raw,
  output logic              ea_valid,
  output logic [ADDR_W-1:0] ea_addr,
  output logic              ea_misalign,
  output logic              ea_size_err,
  output logic              ea_base_gbr
);

  // named internal events, also observed by the checker
  logic [ADDR_W-1:0] ea_base;
  logic [ADDR_W-1:0] ea_offset;
  logic [ADDR_W-1:0] ea_sum;
  logic              base_is_gbr;
  logic              mis_now;
  logic              size_bad;
  logic              accept;
  logic              reject;

  ea_base_sel #(.ADDR_W(ADDR_W)) u_base (
    .mode        (req_mode),
    .rn          (rn_val),
    .gbr         (gbr_val),
    .base        (ea_base),
    .base_is_gbr (base_is_gbr)
  );

  ea_offset_sel #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .SHORT_W(SHORT_W)) u_off (
    .mode   (req_mode),
    .size   (req_size),
    .disp   (disp_raw),
    .r0     (r0_val),
    .offset (ea_offset)
  );

  // modulo 2^ADDR_W: the carry out is simply not kept
  assign ea_sum = ea_base + ea_offset;

  ea_align_chk u_align (
    .addr_lo    (ea_sum[1:0]),
    .size       (req_size),
    .misaligned (mis_now),
    .size_bad   (size_bad)
  );

  assign accept = req_valid && !size_bad;
  assign reject = req_valid && size_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_valid    <= 1'b0;
      ea_size_err <= 1'b0;
      ea_addr     <= '0;
      ea_misalign <= 1'b0;
      ea_base_gbr <= 1'b0;
    end else begin
      ea_valid    <= accept;
      ea_size_err <= reject;
      if (accept) begin
        ea_addr     <= ea_sum;
        ea_misalign <= mis_now;
        ea_base_gbr <= base_is_gbr;
      end
    end
  end

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_mode,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] ea_offset,
  input logic              ea_valid,
  input logic [ADDR_W-1:0] ea_addr,
  input logic              ea_misalign,
  input logic              ea_size_err,
  input logic              ea_base_gbr
);

  AST_LEGAL_GIVES_VALID: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size != 2'b11) |=> (ea_valid && !ea_size_err)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!ea_valid && !ea_size_err && $stable(ea_addr))); // R9

  AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'b11) |=> (ea_size_err && !ea_valid && $stable(ea_addr))); // R7

  AST_SHORT_REACH: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'b00) |-> (ea_offset <= ADDR_W'(60))); // R1

  AST_LONG_REACH: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'b10) |-> (ea_offset <= ADDR_W'(1020))); // R2

  AST_BYTE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'b00) |=> !ea_misalign); // R8

  AST_LONG_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size == 2'b10) |=> (ea_misalign == (ea_addr[1:0] != 2'b00))); // R8

  AST_BASE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size != 2'b11) |=> (ea_base_gbr == $past(req_mode[1]))); // R10

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!ea_valid && !ea_size_err && ea_addr == '0)); // R11

endmodule

bind ldst_ea_gen ea_gen_chk #(.ADDR_W(ADDR_W)) u_ea_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_mode    (req_mode),
  .req_size    (req_size),
  .ea_offset   (ea_offset),
  .ea_valid    (ea_valid),
  .ea_addr     (ea_addr),
  .ea_misalign (ea_misalign),
  .ea_size_err (ea_size_err),
  .ea_base_gbr (ea_base_gbr)
);

// File: tb/ldst_ea_gen_test.sv
`timescale 1ns/1ps
module ldst_ea_gen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_mode = 2'b00;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] rn_val = '0;
  logic [31:0] r0_val = '0;
  logic [31:0] gbr_val = '0;
  logic [7:0]  disp_raw = '0;
  logic        ea_valid;
  logic [31:0] ea_addr;
  logic        ea_misalign;
  logic        ea_size_err;
  logic        ea_base_gbr;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  ldst_ea_gen uut (
    .clk (clk), .rst (rst), .req_valid (req_valid), .req_mode (req_mode),
    .req_size (req_size), .rn_val (rn_val), .r0_val (r0_val), .gbr_val (gbr_val),
    .disp_raw (disp_raw), .ea_valid (ea_valid), .ea_addr (ea_addr),
    .ea_misalign (ea_misalign), .ea_size_err (ea_size_err), .ea_base_gbr (ea_base_gbr)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected address restated with multiplication and 64-bit sums
  function automatic logic [63:0] ref_sum(input int m, input int s, input logic [31:0] rn,
                                          input logic [31:0] r0, input logic [31:0] gbr,
                                          input int d);
    longint mult;
    longint dd;
    mult = (s == 0) ? 1 : (s == 1) ? 2 : 4;
    dd   = (m == 0) ? (d % 16) : d;
    case (m)
      0:       ref_sum = 64'(rn)  + 64'(dd * mult);
      1:       ref_sum = 64'(rn)  + 64'(r0);
      2:       ref_sum = 64'(gbr) + 64'(dd * mult);
      default: ref_sum = 64'(gbr) + 64'(r0);
    endcase
  endfunction

  function automatic bit ref_mis(input int s, input logic [31:0] a);
    if (s == 1)      ref_mis = (a % 2) != 0;
    else if (s == 2) ref_mis = (a % 4) != 0;
    else             ref_mis = 1'b0;
  endfunction

  logic [31:0] rn_set  [4] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFC1, 32'h1234_5678};
  logic [31:0] gbr_set [4] = '{32'hFFFF_FC02, 32'h0000_0000, 32'h8000_0003, 32'hFFFF_FFFF};
  logic [31:0] r0_set  [4] = '{32'hFFFF_FFFF, 32'h0000_0007, 32'h0000_0004, 32'h8000_0001};

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin : main
    logic [31:0] last_addr;
    logic [63:0] s64;
    logic [31:0] exp_a;
    string       tag;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(ea_valid == 0 && ea_size_err == 0, "R11 valid/err after reset", {30'd0, ea_valid, ea_size_err}, 0);
    check(ea_addr == 0 && ea_misalign == 0 && ea_base_gbr == 0, "R11 addr/flags after reset", ea_addr, 0);
    last_addr = '0;

    for (int b = 0; b < 4; b++) begin
      for (int m = 0; m < 4; m++) begin
        for (int s = 0; s < 4; s++) begin
          for (int d = 0; d < 256; d++) begin
            rn_val = rn_set[b]; gbr_val = gbr_set[b]; r0_val = r0_set[b];
            req_mode = 2'(m); req_size = 2'(s); disp_raw = 8'(d);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            if (s == 3) begin
              check(ea_size_err == 1 && ea_valid == 0, "R7 error pulse", {30'd0, ea_valid, ea_size_err}, 1);
              check(ea_addr == last_addr, "R7 addr held on bad size", ea_addr, last_addr);
            end else begin
              s64   = ref_sum(m, s, rn_set[b], r0_set[b], gbr_set[b], d);
              exp_a = s64[31:0];
              case (m)
                0:       tag = "R1/R3 Rn+disp";
                1:       tag = "R4 Rn+R0";
                2:       tag = "R2/R3 GBR+disp";
                default: tag = "R5 GBR+R0";
              endcase
              if (s64[63:32] != 0) tag = {tag, " R6 wrap"};
              check(ea_valid == 1 && ea_size_err == 0, "R9 valid pulse", {30'd0, ea_valid, ea_size_err}, 2);
              check(ea_addr == exp_a, tag, ea_addr, exp_a);
              check(ea_misalign == ref_mis(s, exp_a), "R8 misalign", {31'd0, ea_misalign}, {31'd0, ref_mis(s, exp_a)});
              check(ea_base_gbr == (m >= 2), "R10 base flag", {31'd0, ea_base_gbr}, {31'd0, m >= 2});
              last_addr = exp_a;
            end
            @(negedge clk);
            check(ea_valid == 0 && ea_size_err == 0, "R9 idle no pulse", {30'd0, ea_valid, ea_size_err}, 0);
            check(ea_addr == last_addr, "R9 addr held idle", ea_addr, last_addr);
          end
        end
      end
    end

    // R11 reset wins over a simultaneous legal request
    rn_val = 32'h0000_1001; req_mode = 2'b10; req_size = 2'b01; gbr_val = 32'h0000_0101;
    req_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; rst = 1'b0;
    check(ea_valid == 0 && ea_size_err == 0, "R11 reset beats request", {30'd0, ea_valid, ea_size_err}, 0);
    check(ea_addr == 0 && ea_misalign == 0 && ea_base_gbr == 0, "R11 outputs cleared", ea_addr, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule